// File: doc/BRIEF.md
# SCSI Message-In Decoder

This block sits on the initiator side of a parallel SCSI bus controller and parses the bytes a target sends during the message-in phase. Bytes arrive one at a time under a valid/acknowledge handshake. The decoder captures each byte and acknowledges it. It then walks through single-byte, identify, extended and simple-queue-tag messages.

When a message ends, the decoder fires exactly one single-cycle event strobe. Where the message carries arguments (LUN, transfer period and offset, bus width, tag), the decoder latches them in output registers. These stay stable until a later message replaces them.

Malformed or unsupported messages are never dropped silently. The decoder pulses an ATN request and places the reply byte in a held register for the message-out logic to send. The reply is message reject, or abort tag for an out-of-range tag. The first byte of every message is also kept, so that a rejected message can be reported.

Top module: `scsi_msgin_decoder`

## Requirements
- R1: A byte is captured at the clock edge where `rx_valid` and `msg_in_phase` are both high and `rx_ack` is low. `rx_ack` is then high for exactly the following cycle. While `msg_in_phase` is low, no byte is acknowledged and no output changes.
- R2: The first-byte codes 0x00, 0x02, 0x03, 0x04 and 0x07 each end a message. They pulse `ev_cmd_done`, `ev_save_ptrs`, `ev_restore_ptrs`, `ev_disconnect` and `ev_reject_seen` respectively.
- R3: A first byte with bit 7 set and bits [6:3] clear pulses `ev_identify`. `lun_value` then holds bits [2:0] of that byte.
- R4: A first byte with bit 7 set and any of bits [6:3] set is rejected: `atn_assert` pulses and `reply_byte` becomes 0x07.
- R5: The sequence 0x01, 3, 0x01, period, offset pulses `ev_sync` on the last byte. `sync_period` and `sync_offset` then hold the fourth and fifth bytes.
- R6: The sequence 0x01, 2, 0x03, width pulses `ev_wide` on the last byte, and `wide_width` holds the width byte.
- R7: In an extended message, the second byte is the length and the third is the code. A length that does not match its code, or an unknown code, causes `atn_assert` with `reply_byte` 0x07 on the code byte, and the next byte starts a new message.
- R8: Any other first byte (0x05, 0x06, 0x08 to 0x1F, 0x21 to 0x7F) causes `atn_assert` with `reply_byte` 0x07.
- R9: A first byte 0x20 is followed by a tag byte. If the tag's upper four bits are zero, `ev_tag` pulses and `tag_value` holds the lower four bits. Otherwise `atn_assert` pulses with `reply_byte` 0x0D.
- R10: `first_byte` holds the first byte of the most recent message from the cycle after that byte is captured.
- R11: If `msg_in_phase` falls in the middle of a message, the partial message is dropped, and the next byte captured is treated as a first byte.
- R12: Every event strobe and `atn_assert` is high for one cycle only, at most one of them is high in any cycle, and each coincides with the `rx_ack` of the byte that completed the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_in_phase | input | 1 | Bus is in the message-in phase |
| rx_valid | input | 1 | Received byte is present |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | Byte accepted, one cycle |
| ev_cmd_done | output | 1 | Command complete strobe |
| ev_save_ptrs | output | 1 | Save data pointers strobe |
| ev_restore_ptrs | output | 1 | Restore pointers strobe |
| ev_disconnect | output | 1 | Disconnect strobe |
| ev_reject_seen | output | 1 | Target rejected our message |
| ev_identify | output | 1 | Valid identify received |
| ev_sync | output | 1 | Synchronous negotiation received |
| ev_wide | output | 1 | Wide negotiation received |
| ev_tag | output | 1 | Valid simple-queue tag received |
| atn_assert | output | 1 | Request ATN and send `reply_byte` |
| reply_byte | output | 8 | Queued reply message byte |
| first_byte | output | 8 | First byte of latest message |
| lun_value | output | 3 | LUN from identify |
| sync_period | output | 8 | Transfer period argument |
| sync_offset | output | 8 | REQ/ACK offset argument |
| wide_width | output | 8 | Bus width argument |
| tag_value | output | TAG_W | Tag from tag message |

## Verification
The bench sweeps all 256 first-byte values. This catches a classifier that accepts an identify byte with a reserved bit set, or one that lets an unknown code pass without a reject. All 256 tag bytes are also swept, so a wrong nibble boundary shows up as a missed abort or a false abort. Swapped extended lengths are tried, because a design that checked length against the wrong code would start a negotiation on bad input. Two further cases cover a byte offered outside the phase, which a careless design would still acknowledge, and a phase drop mid-message, after which a stale parser would read a disconnect as an extended length.

// File: rtl/msgin_pkg.sv
package msgin_pkg;
   typedef enum logic [3:0] {
      K_CMD_DONE, K_EXTENDED, K_SAVE, K_RESTORE, K_DISC,
      K_REJ_SEEN, K_IDENT, K_TAG, K_BAD
   } kind_e;

   typedef enum logic [2:0] {
      ST_FIRST, ST_XLEN, ST_XCODE, ST_SPER, ST_SOFF, ST_WIDTH, ST_TAGB
   } pstate_e;

   localparam int LUN_W = 3;
endpackage

// File: rtl/msgin_classify.sv
module msgin_classify import msgin_pkg::*; #(
   parameter bit EN_TAG = 1'b1
) (
   input  logic [7:0]       b,
   output kind_e            kind,
   output logic [LUN_W-1:0] lun
);
   logic is_tag;

   generate
      if (EN_TAG) begin : g_tag
         assign is_tag = (b == 8'h20);
      end else begin : g_notag
         assign is_tag = 1'b0;
      end
   endgenerate

   assign lun = b[LUN_W-1:0];

   always_comb begin
      if (b[7]) begin
         kind = (b[6:3] == 4'd0) ? K_IDENT : K_BAD;
      end else if (is_tag) begin
         kind = K_TAG;
      end else begin
         case (b)
            8'h00:   kind = K_CMD_DONE;
            8'h01:   kind = K_EXTENDED;
            8'h02:   kind = K_SAVE;
            8'h03:   kind = K_RESTORE;
            8'h04:   kind = K_DISC;
            8'h07:   kind = K_REJ_SEEN;
            default: kind = K_BAD;
         endcase
      end
   end
endmodule

// File: rtl/msgin_ext_check.sv
module msgin_ext_check #(
   parameter int SYNC_LEN = 3,
   parameter int WIDE_LEN = 2
) (
   input  logic [7:0] ext_len,
   input  logic [7:0] ext_code,
   output logic       go_sync,
   output logic       go_wide
);
   localparam logic [7:0] SYNC_CODE = 8'h01;
   localparam logic [7:0] WIDE_CODE = 8'h03;
   localparam logic [7:0] SLEN      = 8'(SYNC_LEN);
   localparam logic [7:0] WLEN      = 8'(WIDE_LEN);

   initial begin
      if (SYNC_LEN < 1 || SYNC_LEN > 255) $error("SYNC_LEN out of range");
      if (WIDE_LEN < 1 || WIDE_LEN > 255) $error("WIDE_LEN out of range");
   end

   assign go_sync = (ext_code == SYNC_CODE) && (ext_len == SLEN);
   assign go_wide = (ext_code == WIDE_CODE) && (ext_len == WLEN);
endmodule

// File: rtl/msgin_ack_gen.sv
module msgin_ack_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_valid,
   input  logic msg_in_phase,
   output logic take,
   output logic rx_ack
);
   assign take = rx_valid && msg_in_phase && !rx_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_ack <= 1'b0;
      else        rx_ack <= take;
   end

   assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |=> !rx_ack);
   assert_ack_in_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |-> $past(msg_in_phase) && $past(rx_valid));
endmodule

// File: rtl/scsi_msgin_decoder.sv
module scsi_msgin_decoder import msgin_pkg::*; #(
   parameter bit         EN_TAG         = 1'b1,
   parameter int         TAG_W          = 4,
   parameter int         SYNC_LEN       = 3,
   parameter int         WIDE_LEN       = 2,
   parameter logic [7:0] REJECT_CODE    = 8'h07,
   parameter logic [7:0] ABORT_TAG_CODE = 8'h0D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_in_phase,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   output logic             rx_ack,
   output logic             ev_cmd_done,
   output logic             ev_save_ptrs,
   output logic             ev_restore_ptrs,
   output logic             ev_disconnect,
   output logic             ev_reject_seen,
   output logic             ev_identify,
   output logic             ev_sync,
   output logic             ev_wide,
   output logic             ev_tag,
   output logic             atn_assert,
   output logic [7:0]       reply_byte,
   output logic [7:0]       first_byte,
   output logic [2:0]       lun_value,
   output logic [7:0]       sync_period,
   output logic [7:0]       sync_offset,
   output logic [7:0]       wide_width,
   output logic [TAG_W-1:0] tag_value
);
   initial begin
      if (TAG_W < 1 || TAG_W > 8) $error("TAG_W must be 1..8");
      if (REJECT_CODE == ABORT_TAG_CODE) $error("reply codes must differ");
   end

   pstate_e          state;
   kind_e            kind;
   logic [LUN_W-1:0] lun_c;
   logic             take, go_sync, go_wide, tag_ok;
   logic [7:0]       ext_len;

   msgin_ack_gen u_ack (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
      .msg_in_phase(msg_in_phase), .take(take), .rx_ack(rx_ack));

   msgin_classify #(.EN_TAG(EN_TAG)) u_cls (
      .b(rx_data), .kind(kind), .lun(lun_c));

   msgin_ext_check #(.SYNC_LEN(SYNC_LEN), .WIDE_LEN(WIDE_LEN)) u_ext (
      .ext_len(ext_len), .ext_code(rx_data),
      .go_sync(go_sync), .go_wide(go_wide));

   assign tag_ok = ((rx_data >> TAG_W) == 8'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state           <= ST_FIRST;
         ev_cmd_done     <= 1'b0;
         ev_save_ptrs    <= 1'b0;
         ev_restore_ptrs <= 1'b0;
         ev_disconnect   <= 1'b0;
         ev_reject_seen  <= 1'b0;
         ev_identify     <= 1'b0;
         ev_sync         <= 1'b0;
         ev_wide         <= 1'b0;
         ev_tag          <= 1'b0;
         atn_assert      <= 1'b0;
         reply_byte      <= 8'd0;
         first_byte      <= 8'd0;
         lun_value       <= 3'd0;
         sync_period     <= 8'd0;
         sync_offset     <= 8'd0;
         wide_width      <= 8'd0;
         tag_value       <= '0;
         ext_len         <= 8'd0;
      end else begin
         ev_cmd_done     <= 1'b0;
         ev_save_ptrs    <= 1'b0;
         ev_restore_ptrs <= 1'b0;
         ev_disconnect   <= 1'b0;
         ev_reject_seen  <= 1'b0;
         ev_identify     <= 1'b0;
         ev_sync         <= 1'b0;
         ev_wide         <= 1'b0;
         ev_tag          <= 1'b0;
         atn_assert      <= 1'b0;
         if (!msg_in_phase) begin
            state <= ST_FIRST;
         end else if (take) begin
            case (state)
               ST_FIRST: begin
                  first_byte <= rx_data;
                  case (kind)
                     K_CMD_DONE: ev_cmd_done     <= 1'b1;
                     K_SAVE:     ev_save_ptrs    <= 1'b1;
                     K_RESTORE:  ev_restore_ptrs <= 1'b1;
                     K_DISC:     ev_disconnect   <= 1'b1;
                     K_REJ_SEEN: ev_reject_seen  <= 1'b1;
                     K_IDENT: begin
                        ev_identify <= 1'b1;
                        lun_value   <= lun_c;
                     end
                     K_EXTENDED: state <= ST_XLEN;
                     K_TAG:      state <= ST_TAGB;
                     default: begin
                        atn_assert <= 1'b1;
                        reply_byte <= REJECT_CODE;
                     end
                  endcase
               end
               ST_XLEN: begin
                  ext_len <= rx_data;
                  state   <= ST_XCODE;
               end
               ST_XCODE: begin
                  if (go_sync)      state <= ST_SPER;
                  else if (go_wide) state <= ST_WIDTH;
                  else begin
                     atn_assert <= 1'b1;
                     reply_byte <= REJECT_CODE;
                     state      <= ST_FIRST;
                  end
               end
               ST_SPER: begin
                  sync_period <= rx_data;
                  state       <= ST_SOFF;
               end
               ST_SOFF: begin
                  sync_offset <= rx_data;
                  ev_sync     <= 1'b1;
                  state       <= ST_FIRST;
               end
               ST_WIDTH: begin
                  wide_width <= rx_data;
                  ev_wide    <= 1'b1;
                  state      <= ST_FIRST;
               end
               ST_TAGB: begin
                  if (tag_ok) begin
                     tag_value <= rx_data[TAG_W-1:0];
                     ev_tag    <= 1'b1;
                  end else begin
                     atn_assert <= 1'b1;
                     reply_byte <= ABORT_TAG_CODE;
                  end
                  state <= ST_FIRST;
               end
               default: state <= ST_FIRST;
            endcase
         end
      end
   end

   logic [9:0] strobes;
   assign strobes = {ev_cmd_done, ev_save_ptrs, ev_restore_ptrs, ev_disconnect,
                     ev_reject_seen, ev_identify, ev_sync, ev_wide, ev_tag, atn_assert};

   assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobes));
   assert_strobe_with_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes != 10'd0) |-> rx_ack);
   assert_strobe_short_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes != 10'd0) |=> (strobes == 10'd0));
   assert_reply_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      atn_assert |-> (reply_byte == REJECT_CODE || reply_byte == ABORT_TAG_CODE));
   assert_ident_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_identify |-> (first_byte[7:3] == 5'b10000) && (lun_value == first_byte[2:0]));
   assert_phase_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(msg_in_phase) |-> (strobes == 10'd0));
endmodule

// File: tb/test_scsi_msgin_decoder.sv
`timescale 1ns/1ps
module test_scsi_msgin_decoder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic msg_in_phase = 1'b0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_data = 8'd0;
   logic rx_ack, ev_cmd_done, ev_save_ptrs, ev_restore_ptrs, ev_disconnect;
   logic ev_reject_seen, ev_identify, ev_sync, ev_wide, ev_tag, atn_assert;
   logic [7:0] reply_byte, first_byte, sync_period, sync_offset, wide_width;
   logic [2:0] lun_value;
   logic [3:0] tag_value;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   scsi_msgin_decoder i_scsi_msgin_decoder (.*);

   // bit order: 9 cmd, 8 save, 7 restore, 6 disc, 5 rej_seen, 4 ident, 3 sync, 2 wide, 1 tag, 0 atn
   wire [9:0] evv = {ev_cmd_done, ev_save_ptrs, ev_restore_ptrs, ev_disconnect,
                     ev_reject_seen, ev_identify, ev_sync, ev_wide, ev_tag, atn_assert};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, output logic [9:0] ev);
      int n;
      rx_data = b;
      rx_valid = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!rx_ack && n < 20);
      ev = evv;
      rx_valid = 1'b0;
      check("R1 ack seen", {31'd0, rx_ack}, 32'd1);
      @(negedge clk);
      check("R12 strobe cleared", {22'd0, evv}, 32'd0);
   endtask

   logic [9:0] ev;

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      if (!done) begin
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset ack", {31'd0, rx_ack}, 32'd0);
      check("R12 reset strobes", {22'd0, evv}, 32'd0);
      rst_n = 1'b1;
      msg_in_phase = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R8 R10: sweep all first bytes
      for (int b = 0; b < 256; b++) begin
         logic [9:0] exp;
         send(8'(b), ev);
         exp = 10'd0;
         if (b >= 128) exp = ((b & 8'h78) == 0) ? 10'h010 : 10'h001;
         else if (b == 0) exp = 10'h200;
         else if (b == 2) exp = 10'h100;
         else if (b == 3) exp = 10'h080;
         else if (b == 4) exp = 10'h040;
         else if (b == 7) exp = 10'h020;
         else if (b == 1 || b == 32) exp = 10'h000;
         else exp = 10'h001;
         check("R2 R3 R4 R8 first-byte event", {22'd0, ev}, {22'd0, exp});
         check("R10 first_byte", {24'd0, first_byte}, b);
         if (exp == 10'h001) check("R8 reply reject", {24'd0, reply_byte}, 32'h07);
         if (exp == 10'h010) check("R3 lun", {29'd0, lun_value}, b & 7);
         if (b == 1) begin
            send(8'h05, ev);
            send(8'h7F, ev);
            check("R7 unknown ext code", {22'd0, ev}, 32'h001);
            check("R7 reply", {24'd0, reply_byte}, 32'h07);
         end
         if (b == 32) begin
            send(8'h05, ev);
            check("R9 tag ok", {22'd0, ev}, 32'h002);
            check("R9 tag value", {28'd0, tag_value}, 32'h5);
         end
      end

      // R5: synchronous negotiation, a few argument pairs
      for (int k = 0; k < 6; k++) begin
         logic [7:0] per, off;
         per = 8'(k * 37 + 12);
         off = 8'(255 - k * 29);
         send(8'h01, ev); send(8'h03, ev); send(8'h01, ev); send(per, ev);
         check("R5 no early event", {22'd0, ev}, 32'd0);
         send(off, ev);
         check("R5 sync event", {22'd0, ev}, 32'h008);
         check("R5 period", {24'd0, sync_period}, per);
         check("R5 offset", {24'd0, sync_offset}, off);
      end

      // R6: wide negotiation
      for (int w = 0; w < 4; w++) begin
         send(8'h01, ev); send(8'h02, ev); send(8'h03, ev); send(8'(w), ev);
         check("R6 wide event", {22'd0, ev}, 32'h004);
         check("R6 width", {24'd0, wide_width}, w);
      end

      // R7: swapped lengths, then a following byte starts a new message
      send(8'h01, ev); send(8'h02, ev); send(8'h01, ev);
      check("R7 sync bad length", {22'd0, ev}, 32'h001);
      send(8'h04, ev);
      check("R7 fresh message after reject", {22'd0, ev}, 32'h040);
      send(8'h01, ev); send(8'h03, ev); send(8'h03, ev);
      check("R7 wide bad length", {22'd0, ev}, 32'h001);
      check("R7 reply", {24'd0, reply_byte}, 32'h07);

      // R9: sweep tag byte
      for (int t = 0; t < 256; t++) begin
         send(8'h20, ev);
         send(8'(t), ev);
         if (t < 16) begin
            check("R9 tag event", {22'd0, ev}, 32'h002);
            check("R9 tag value", {28'd0, tag_value}, t);
         end else begin
            check("R9 abort tag", {22'd0, ev}, 32'h001);
            check("R9 abort reply", {24'd0, reply_byte}, 32'h0D);
         end
      end

      // R1: byte offered outside the phase is ignored
      send(8'h02, ev);
      msg_in_phase = 1'b0;
      rx_data = 8'h00;
      rx_valid = 1'b1;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         check("R1 no ack outside phase", {31'd0, rx_ack}, 32'd0);
         check("R1 no event outside phase", {22'd0, evv}, 32'd0);
      end
      rx_valid = 1'b0;
      check("R1 first_byte untouched", {24'd0, first_byte}, 32'h02);
      msg_in_phase = 1'b1;
      @(negedge clk);

      // R11: phase drop in mid message
      send(8'h01, ev);
      msg_in_phase = 1'b0;
      @(negedge clk);
      msg_in_phase = 1'b1;
      @(negedge clk);
      send(8'h04, ev);
      check("R11 abandoned partial message", {22'd0, ev}, 32'h040);
      check("R11 first_byte", {24'd0, first_byte}, 32'h04);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule